// File: doc/BRIEF.md
# Memory Wait-State Timing Guard

This block paces accesses to a slow nonvolatile memory. A programmed wait count N (0 to 15) sets how many interface-clock periods each access is held before it completes. When automatic selection is enabled, a fixed value set by a parameter is used instead. The block also accepts a strobe from an external access-time monitor. When that strobe fires, the block latches an error flag and enters a safe mode:

- the wait count is forced to its maximum;
- reprogramming of the wait count is refused;
- every memory write is suppressed, while reads still complete normally.

Software leaves the safe mode by pulsing a flag-clear strobe. The forced maximum stays in place until software loads a new value.

If the interrupt enable is set, the violation also raises a non-maskable interrupt request. A parameter selects whether that request is a one-cycle pulse or a level that follows the error flag.

Top module: `nvm_wait_guard`

## Requirements
- R1: With automatic selection off and the flag clear, a request accepted at a clock edge is answered by a one-cycle `ready_o` pulse that is high after the edge N+1 cycles later. N is the value last loaded through `wait_load_i`, and `wait_eff_o` equals N.
- R2: With N = 0, `ready_o` is high in the cycle directly after the accepting edge.
- R3: A cycle with `viol_i` high sets `err_o` after that edge. While `err_o` is high, `wait_eff_o` reads 15 whatever the mode.
- R4: While `err_o` is high, a `wait_load_i` pulse is ignored. This includes the cycle in which `flag_clr_i` is pulsed.
- R5: A write whose completing edge sees `err_o` high, or sees `viol_i` high, gives `mem_we_o` = 0. Reads under the flag still complete with `ready_o` after 16 cycles.
- R6: `flag_clr_i` drops `err_o` after the edge, except that a `viol_i` in the same cycle keeps it set. Once the flag is clear, loads are accepted and writes again pulse `mem_we_o` together with `ready_o`.
- R7: A violation with `irq_en_i` high makes `nmi_o` high for exactly the next cycle. With `irq_en_i` low, `nmi_o` stays low.
- R8: After the flag is cleared, `wait_eff_o` stays 15 until a new value is loaded.
- R9: A write accepted while `wprot_i` is high never pulses `mem_we_o`, even with the flag clear.
- R10: With `auto_i` high and the flag clear, `wait_eff_o` equals AUTO_WAITS (default 0), and accesses use it.
- R11: After reset, `ready_o`, `mem_we_o`, `err_o` and `nmi_o` are 0 and `wait_eff_o` is 0.
- R12: A request raised while an access is still counting is ignored. Only one `ready_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when idle |
| wr_i | input | 1 | 1 = write access, 0 = read |
| wait_val_i | input | WAIT_W | Wait count to load |
| wait_load_i | input | 1 | Strobe that loads `wait_val_i` |
| auto_i | input | 1 | Use the automatic wait value |
| wprot_i | input | 1 | Write protect |
| viol_i | input | 1 | Timing-violation strobe from the monitor |
| flag_clr_i | input | 1 | Clears the error flag |
| irq_en_i | input | 1 | Interrupt enable for violations |
| ready_o | output | 1 | One-cycle access completion |
| mem_we_o | output | 1 | Memory write enable, pulsed with `ready_o` |
| wait_eff_o | output | WAIT_W | Wait count currently in force |
| err_o | output | 1 | Access-time error flag |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Two events can fall in the same cycle and must be resolved:

- **A violation and the completion of a write.** The bench raises `viol_i` in the last cycle of a write access that was started with the flag clear. It then checks that `ready_o` still arrives after N+1 cycles while `mem_we_o` stays low.
- **A flag clear and a violation, or a flag clear and a wait load.** The bench pulses these together. It expects the flag to stay set in the first case. In the second case it expects the flag to clear while the load is refused, so `wait_eff_o` remains 15.

// File: rtl/nvm_wait_pkg.sv
package nvm_wait_pkg;
   typedef enum logic {
      ACC_IDLE = 1'b0,
      ACC_WAIT = 1'b1
   } acc_state_e;
endpackage

// File: rtl/nvm_wait_cfg.sv
module nvm_wait_cfg #(
   parameter int WAIT_W     = 4,
   parameter int AUTO_WAITS = 0,
   parameter bit NMI_LEVEL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WAIT_W-1:0] wait_val_i,
   input  logic              wait_load_i,
   input  logic              auto_i,
   input  logic              viol_i,
   input  logic              flag_clr_i,
   input  logic              irq_en_i,
   output logic [WAIT_W-1:0] wait_eff_o,
   output logic              err_o,
   output logic              nmi_o
);
   localparam logic [WAIT_W-1:0] MAX_WAIT  = {WAIT_W{1'b1}};
   localparam logic [WAIT_W-1:0] AUTO_VAL  = WAIT_W'(AUTO_WAITS);

   logic              err_q;
   logic [WAIT_W-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (viol_i) begin
         err_q <= 1'b1;
      end else if (flag_clr_i) begin
         err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
      end else if (viol_i) begin
         wait_q <= MAX_WAIT;
      end else if (wait_load_i && !err_q) begin
         wait_q <= wait_val_i;
      end
   end

   always_comb begin
      if (err_q)       wait_eff_o = MAX_WAIT;
      else if (auto_i) wait_eff_o = AUTO_VAL;
      else             wait_eff_o = wait_q;
   end

   assign err_o = err_q;

   generate
      if (NMI_LEVEL) begin : g_nmi_level
         assign nmi_o = err_q & irq_en_i;
      end else begin : g_nmi_pulse
         logic nmi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nmi_q <= 1'b0;
            else        nmi_q <= viol_i & irq_en_i;
         end
         assign nmi_o = nmi_q;

         assert_nmi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (viol_i && irq_en_i) |=> nmi_o);
         assert_nmi_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en_i |=> !nmi_o);
      end
   endgenerate

   assert_err_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      viol_i |=> (err_o && wait_eff_o == MAX_WAIT));
   assert_load_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> $stable(wait_q));
   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !viol_i) |=> !err_o);
endmodule

// File: rtl/nvm_wait_seq.sv
module nvm_wait_seq
   import nvm_wait_pkg::*;
#(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic              wprot_i,
   input  logic [WAIT_W-1:0] wait_eff_i,
   input  logic              blk_i,
   output logic              ready_o,
   output logic              mem_we_o
);
   localparam int EW = WAIT_W + 1;

   acc_state_e        st_q;
   logic [WAIT_W-1:0] cnt_q;
   logic              wr_q, wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ACC_IDLE;
         cnt_q    <= '0;
         wr_q     <= 1'b0;
         wp_q     <= 1'b0;
         ready_o  <= 1'b0;
         mem_we_o <= 1'b0;
      end else begin
         ready_o  <= 1'b0;
         mem_we_o <= 1'b0;
         case (st_q)
            ACC_IDLE: if (req_i) begin
               st_q  <= ACC_WAIT;
               cnt_q <= wait_eff_i;
               wr_q  <= wr_i;
               wp_q  <= wprot_i;
            end
            ACC_WAIT: if (cnt_q == '0) begin
               st_q     <= ACC_IDLE;
               ready_o  <= 1'b1;
               mem_we_o <= wr_q & ~wp_q & ~blk_i;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= ACC_IDLE;
         endcase
      end
   end

   // independent latency tracker for the N+1 check
   logic [EW-1:0]     el_q;
   logic [WAIT_W-1:0] n_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         el_q <= '0;
         n_q  <= '0;
      end else if (st_q == ACC_IDLE && req_i) begin
         el_q <= EW'(1);
         n_q  <= wait_eff_i;
      end else if (st_q == ACC_WAIT) begin
         el_q <= el_q + 1'b1;
      end
   end

   assert_ready_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> ($past(el_q) == {1'b0, $past(n_q)} + 1'b1));
   assert_wprot_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ACC_IDLE && req_i && wprot_i) |=> (!mem_we_o && wp_q));
   assert_we_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> ready_o);
endmodule

// File: rtl/nvm_wait_guard.sv
module nvm_wait_guard #(
   parameter int WAIT_W     = 4,
   parameter int AUTO_WAITS = 0,
   parameter bit NMI_LEVEL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [WAIT_W-1:0] wait_val_i,
   input  logic              wait_load_i,
   input  logic              auto_i,
   input  logic              wprot_i,
   input  logic              viol_i,
   input  logic              flag_clr_i,
   input  logic              irq_en_i,
   output logic              ready_o,
   output logic              mem_we_o,
   output logic [WAIT_W-1:0] wait_eff_o,
   output logic              err_o,
   output logic              nmi_o
);
   localparam int MAX_N = (1 << WAIT_W) - 1;

   generate
      if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_width
         $error("nvm_wait_guard: WAIT_W must lie in 1..8");
      end
      if (AUTO_WAITS < 0 || AUTO_WAITS > MAX_N) begin : g_bad_auto
         $error("nvm_wait_guard: AUTO_WAITS exceeds the wait range");
      end
   endgenerate

   logic              err_w;
   logic [WAIT_W-1:0] weff_w;

   nvm_wait_cfg #(
      .WAIT_W    (WAIT_W),
      .AUTO_WAITS(AUTO_WAITS),
      .NMI_LEVEL (NMI_LEVEL)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_val_i (wait_val_i),
      .wait_load_i(wait_load_i),
      .auto_i     (auto_i),
      .viol_i     (viol_i),
      .flag_clr_i (flag_clr_i),
      .irq_en_i   (irq_en_i),
      .wait_eff_o (weff_w),
      .err_o      (err_w),
      .nmi_o      (nmi_o)
   );

   nvm_wait_seq #(
      .WAIT_W(WAIT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .wr_i      (wr_i),
      .wprot_i   (wprot_i),
      .wait_eff_i(weff_w),
      .blk_i     (err_w | viol_i),
      .ready_o   (ready_o),
      .mem_we_o  (mem_we_o)
   );

   assign wait_eff_o = weff_w;
   assign err_o      = err_w;

   assert_no_write_in_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> !$past(err_w));
   assert_single_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);
endmodule

// File: tb/nvm_wait_guard_bench.sv
module nvm_wait_guard_bench;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 0, wr = 0, load = 0, auto_m = 0, wprot = 0;
   logic viol = 0, clr = 0, irq_en = 0;
   logic [W-1:0] wval = '0;
   logic ready, we, err, nmi;
   logic [W-1:0] weff;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   nvm_wait_guard #(.WAIT_W(W)) u_nvm_wait_guard (
      .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
      .wait_val_i(wval), .wait_load_i(load), .auto_i(auto_m),
      .wprot_i(wprot), .viol_i(viol), .flag_clr_i(clr),
      .irq_en_i(irq_en), .ready_o(ready), .mem_we_o(we),
      .wait_eff_o(weff), .err_o(err), .nmi_o(nmi)
   );

   task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   task automatic load_wait(input int v);
      @(negedge clk);
      wval = W'(v); load = 1;
      @(posedge clk);
      @(negedge clk);
      load = 0;
   endtask

   // pulse viol and/or clr for one cycle; returns at the negedge after the edge
   task automatic strobe(input bit v, input bit c, input bit ld, input int lv);
      @(negedge clk);
      viol = v; clr = c; load = ld; wval = W'(lv);
      @(posedge clk);
      @(negedge clk);
      viol = 0; clr = 0; load = 0;
   endtask

   // one access; measures cycles from accepting edge to ready
   task automatic access(input bit w, input bit wp, input bit viol_end, input int expn,
                         input bit expwe, input string tag);
      int lat;
      bit got_we;
      @(negedge clk);
      req = 1; wr = w; wprot = wp;
      @(posedge clk);
      lat = 0;
      got_we = 0;
      while (lat < 40) begin
         @(negedge clk);
         req = 0; viol = 0;
         if (ready) begin
            got_we = we;
            break;
         end
         if (viol_end && lat == expn) viol = 1;
         @(posedge clk);
         lat++;
      end
      chk(lat == expn + 1, tag, lat, expn + 1);
      chk(got_we == expwe, tag, int'(got_we), int'(expwe));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R11 reset state
      chk(!ready && !we && !err && !nmi, "R11", {ready, we, err, nmi}, 0);
      chk(weff == 0, "R11", weff, 0);

      // R1 / R2 sweep over every wait count, read and write
      for (int n = 0; n < 16; n++) begin
         load_wait(n);
         chk(weff == W'(n), "R1", weff, n);
         access(1'b0, 1'b0, 1'b0, n, 1'b0, (n == 0) ? "R2" : "R1");
         access(1'b1, 1'b0, 1'b0, n, 1'b1, (n == 0) ? "R2" : "R1");
         if (n % 5 == 0) access(1'b1, 1'b1, 1'b0, n, 1'b0, "R9");
      end

      // R12 request during counting is ignored
      load_wait(5);
      begin
         int pulses;
         pulses = 0;
         @(negedge clk); req = 1; wr = 0;
         @(posedge clk);
         @(negedge clk); req = 0;
         @(negedge clk); req = 1;
         @(negedge clk); req = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ready) pulses++;
         end
         chk(pulses == 1, "R12", pulses, 1);
      end

      // R10 automatic selection
      load_wait(9);
      @(negedge clk); auto_m = 1;
      #1 chk(weff == 0, "R10", weff, 0);
      access(1'b0, 1'b0, 1'b0, 0, 1'b0, "R10");
      @(negedge clk); auto_m = 0;
      #1 chk(weff == 9, "R10", weff, 9);

      // R3 / R7 violation with interrupt enabled
      irq_en = 1;
      strobe(1, 0, 0, 0);
      chk(err == 1, "R3", err, 1);
      chk(weff == 15, "R3", weff, 15);
      chk(nmi == 1, "R7", nmi, 1);
      @(negedge clk);
      chk(nmi == 0, "R7", nmi, 0);

      // R4 load refused while flagged
      load_wait(4);
      chk(weff == 15, "R4", weff, 15);
      // R5 writes blocked, reads complete
      access(1'b1, 1'b0, 1'b0, 15, 1'b0, "R5");
      access(1'b0, 1'b0, 1'b0, 15, 1'b0, "R5");
      // R3 auto mode does not override the flag
      @(negedge clk); auto_m = 1;
      #1 chk(weff == 15, "R3", weff, 15);
      @(negedge clk); auto_m = 0;

      // R6 clear and violation together: flag holds
      strobe(1, 1, 0, 0);
      chk(err == 1, "R6", err, 1);
      // R4 / R8 clear and load together: clears, load refused
      strobe(0, 1, 1, 2);
      chk(err == 0, "R6", err, 0);
      chk(weff == 15, "R4", weff, 15);
      @(negedge clk);
      chk(weff == 15, "R8", weff, 15);
      // R6 loads and writes resume
      load_wait(3);
      chk(weff == 3, "R6", weff, 3);
      access(1'b1, 1'b0, 1'b0, 3, 1'b1, "R6");

      // R5 violation in the completing cycle of a write
      access(1'b1, 1'b0, 1'b1, 3, 1'b0, "R5");
      @(negedge clk);
      chk(err == 1, "R5", err, 1);

      // R7 violation with interrupt disabled
      irq_en = 0;
      strobe(0, 1, 0, 0);
      strobe(1, 0, 0, 0);
      chk(nmi == 0, "R7", nmi, 0);
      chk(err == 1, "R3", err, 1);
      strobe(0, 1, 0, 0);
      chk(err == 0, "R6", err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule